// File: doc/BRIEF.md
# Double-Precision Range Select Unit

This block takes two binary64 operands and picks one of them: the smaller or the larger by signed value, or the smaller or the larger by magnitude. It can then rewrite the sign bit of the chosen value. The two low bits of an 8-bit control byte choose the comparison. The next two bits choose the sign treatment. A denormals-as-zero mode input decides whether tiny operands are flushed to signed zero before the comparison.

The block also flags invalid operations and denormal operands. Signaling NaNs, quiet NaNs, zeros of opposite sign and equal magnitudes of opposite sign each follow a fixed rule.

Internally, a classifier runs on each operand. A router then sorts every operand pair into one of seven named resolution paths. The paths are listed below in priority order, highest first:

- SNAN_A: the first operand is a signaling NaN.
- SNAN_B: the second operand is a signaling NaN.
- QNAN_B: the second operand is a quiet NaN.
- QNAN_A: the first operand is a quiet NaN.
- ZERO_TIE: both operands are zeros of opposite sign.
- MAG_TIE: both operands have the same magnitude and opposite signs.
- ORDER: an ordinary comparison.

A sign stage applies the sign control on every path except the two signaling-NaN paths. The result and the flags are registered once. Results therefore appear one clock after the inputs that produced them.

Top module: `rsel_unit`

## Requirements
- R1: A synchronous active-high reset clears `res`, `flag_inv`, `flag_den` and `ctrl_bad` to zero. Outside reset, all outputs reflect the inputs sampled at the previous rising clock edge.
- R2: `ctrl[1:0]` picks the comparison. 00 gives the minimum, 01 the maximum, 10 the smaller magnitude and 11 the larger magnitude. Signed order is a sign-magnitude comparison of the bit patterns. Magnitude order compares bits 62:0. On a tie under the less-or-equal test, the minimum kinds keep operand A and the maximum kinds keep operand B.
- R3: `ctrl[3:2]` sets the result sign. 00 copies the sign of operand A. 01 keeps the sign of the selected value. 10 clears bit 63. 11 sets bit 63.
- R4: A signaling NaN has exponent bits 62:52 all ones, bit 51 clear and a nonzero fraction. If A is a signaling NaN, the result is A with bit 51 set; otherwise, if B is a signaling NaN, the result is B with bit 51 set. In both cases `flag_inv` is 1 and the sign control is ignored.
- R5: A quiet NaN has exponent all ones and bit 51 set. If B is a quiet NaN, A is selected; otherwise, if A is a quiet NaN, B is selected. The sign control then applies, and `flag_inv` stays 0.
- R6: For zeros of opposite sign, codes 00 and 10 yield -0 (0x8000000000000000). Codes 01 and 11 yield +0. Operand order makes no difference.
- R7: For nonzero operands with equal magnitude and opposite signs, code 10 yields the negative operand and code 11 yields the positive operand, whatever the order.
- R8: An operand with exponent zero and a nonzero fraction is denormal. With `daz` set, it is treated as a zero of the same sign, both for comparison and as a returned value, and `flag_den` stays 0. With `daz` clear, `flag_den` is 1 unless the other operand is a quiet NaN or either operand is a signaling NaN.
- R9: `ctrl[7:4]` has no effect on `res` or the flags. `ctrl_bad` is 1 exactly when `ctrl[7:4]` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 64 | Operand A (binary64) |
| op_b | input | 64 | Operand B (binary64) |
| ctrl | input | 8 | [1:0] comparison code, [3:2] sign code, [7:4] must be zero |
| daz | input | 1 | Flush denormal operands to signed zero |
| res | output | 64 | Registered selected result |
| flag_inv | output | 1 | Registered invalid flag |
| flag_den | output | 1 | Registered denormal flag |
| ctrl_bad | output | 1 | Registered flag for nonzero ctrl[7:4] |

## Verification
The bench aims at the priority between the NaN paths and at the tie rules, where a small mistake still gives a plausible number.

Each mistake has a visible symptom:
- Checking B before A for signaling NaNs returns the wrong payload when both operands are signaling NaNs.
- Applying the sign control on a signaling-NaN path flips the sign of a quieted NaN.
- Using ordinary comparison for zeros of opposite sign makes the result depend on operand order.
- Resolving equal-magnitude pairs by order returns the positive operand for code 10.

Denormal cases check that the flag is masked next to a quiet NaN and that flushing also changes the returned value.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

    // Resolution path chosen for an operand pair, in priority order.
    typedef enum logic [2:0] {
        P_SNAN_A   = 3'd0,
        P_SNAN_B   = 3'd1,
        P_QNAN_B   = 3'd2,
        P_QNAN_A   = 3'd3,
        P_ZERO_TIE = 3'd4,
        P_MAG_TIE  = 3'd5,
        P_ORDER    = 3'd6
    } path_e;

    typedef enum logic [1:0] {
        CMP_MIN    = 2'b00,
        CMP_MAX    = 2'b01,
        CMP_MINMAG = 2'b10,
        CMP_MAXMAG = 2'b11
    } cmp_e;

    typedef enum logic [1:0] {
        SGN_SRC_A = 2'b00,
        SGN_PICK  = 2'b01,
        SGN_CLR   = 2'b10,
        SGN_SET   = 2'b11
    } sgn_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_qnan;
        logic is_den;
        logic is_zero;
    } opinfo_t;

endpackage

// File: rtl/rsel_classify.sv
module rsel_classify
    import rsel_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op,
    input  logic         daz,
    output opinfo_t      info,
    output logic [W-1:0] eff
);

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_max;
    logic              exp_zero;
    logic              frac_nz;

    always_comb begin
        expo     = op[W-2:FRAC_W];
        frac     = op[FRAC_W-1:0];
        exp_max  = &expo;
        exp_zero = ~|expo;
        frac_nz  = |frac;

        info.is_nan  = exp_max & frac_nz;
        info.is_snan = exp_max & frac_nz & ~frac[FRAC_W-1];
        info.is_qnan = exp_max & frac[FRAC_W-1];
        info.is_den  = exp_zero & frac_nz;
        info.is_zero = exp_zero & (~frac_nz | daz);

        // Flushed value keeps the sign and clears everything else.
        if (exp_zero && frac_nz && daz) begin
            eff = {op[W-1], {(W-1){1'b0}}};
        end else begin
            eff = op;
        end
    end

endmodule

// File: rtl/rsel_route.sv
module rsel_route
    import rsel_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int QBIT  = FRAC_W - 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  opinfo_t      ia,
    input  opinfo_t      ib,
    input  logic [1:0]   cmp,
    input  logic         daz,
    output path_e        path,
    output logic [W-1:0] pick,
    output logic         inv,
    output logic         den
);

    logic [W-2:0] mag_a;
    logic [W-2:0] mag_b;
    logic         sdiff;
    logic         ord_le;
    logic         mag_le;
    logic         mag_eq;
    cmp_e         cmp_k;

    always_comb begin
        mag_a = a[W-2:0];
        mag_b = b[W-2:0];
        sdiff = a[W-1] ^ b[W-1];
        mag_le = (mag_a <= mag_b);
        mag_eq = (mag_a == mag_b);
        cmp_k  = cmp_e'(cmp);

        // Sign-magnitude ordering of A against B.
        if (sdiff) begin
            ord_le = a[W-1];
        end else if (!a[W-1]) begin
            ord_le = (mag_a <= mag_b);
        end else begin
            ord_le = (mag_a >= mag_b);
        end
    end

    // Path selection, highest priority first.
    always_comb begin
        if (ia.is_snan) begin
            path = P_SNAN_A;
        end else if (ib.is_snan) begin
            path = P_SNAN_B;
        end else if (ib.is_qnan) begin
            path = P_QNAN_B;
        end else if (ia.is_qnan) begin
            path = P_QNAN_A;
        end else if (ia.is_zero && ib.is_zero && sdiff) begin
            path = P_ZERO_TIE;
        end else if (mag_eq && sdiff && cmp[1]) begin
            path = P_MAG_TIE;
        end else begin
            path = P_ORDER;
        end
    end

    always_comb begin
        unique case (path)
            P_SNAN_A: begin
                pick       = a;
                pick[QBIT] = 1'b1;
            end
            P_SNAN_B: begin
                pick       = b;
                pick[QBIT] = 1'b1;
            end
            P_QNAN_B: pick = a;
            P_QNAN_A: pick = b;
            P_ZERO_TIE: begin
                pick = {~cmp[0], {(W-1){1'b0}}};
            end
            P_MAG_TIE: begin
                if (cmp[0]) begin
                    pick = a[W-1] ? b : a;
                end else begin
                    pick = a[W-1] ? a : b;
                end
            end
            P_ORDER: begin
                unique case (cmp_k)
                    CMP_MIN:    pick = ord_le ? a : b;
                    CMP_MAX:    pick = ord_le ? b : a;
                    CMP_MINMAG: pick = mag_le ? a : b;
                    CMP_MAXMAG: pick = mag_le ? b : a;
                    default:    pick = a;
                endcase
            end
            default: pick = a;
        endcase
    end

    always_comb begin
        inv = ia.is_snan | ib.is_snan;
        den = ~daz & ~inv & ((ia.is_den & ~ib.is_qnan) | (ib.is_den & ~ia.is_qnan));
    end

endmodule

// File: rtl/rsel_sign.sv
module rsel_sign
    import rsel_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  path_e        path,
    input  logic [1:0]   sgn,
    input  logic         sign_a,
    input  logic [W-1:0] pick,
    output logic [W-1:0] outv
);

    sgn_e sgn_k;

    always_comb begin
        sgn_k = sgn_e'(sgn);
        outv  = pick;
        unique case (path)
            P_SNAN_A, P_SNAN_B: outv = pick;
            default: begin
                unique case (sgn_k)
                    SGN_SRC_A: outv[W-1] = sign_a;
                    SGN_PICK:  outv[W-1] = pick[W-1];
                    SGN_CLR:   outv[W-1] = 1'b0;
                    SGN_SET:   outv[W-1] = 1'b1;
                    default:   outv[W-1] = pick[W-1];
                endcase
            end
        endcase
    end

endmodule

// File: rtl/rsel_unit.sv
module rsel_unit
    import rsel_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int CTRL_W = 8,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              daz,
    output logic [W-1:0]      res,
    output logic              flag_inv,
    output logic              flag_den,
    output logic              ctrl_bad
);

    logic [1:0][W-1:0] raw;
    logic [1:0][W-1:0] eff;
    opinfo_t [1:0]     info;

    path_e        path;
    logic [W-1:0] pick;
    logic [W-1:0] nxt_res;
    logic         nxt_inv;
    logic         nxt_den;
    logic         nxt_bad;

    assign raw[0] = op_a;
    assign raw[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        rsel_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op   (raw[g]),
            .daz  (daz),
            .info (info[g]),
            .eff  (eff[g])
        );
    end

    rsel_route #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_route (
        .a    (eff[0]),
        .b    (eff[1]),
        .ia   (info[0]),
        .ib   (info[1]),
        .cmp  (ctrl[1:0]),
        .daz  (daz),
        .path (path),
        .pick (pick),
        .inv  (nxt_inv),
        .den  (nxt_den)
    );

    rsel_sign #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sign (
        .path   (path),
        .sgn    (ctrl[3:2]),
        .sign_a (op_a[W-1]),
        .pick   (pick),
        .outv   (nxt_res)
    );

    assign nxt_bad = |ctrl[CTRL_W-1:4];

    always_ff @(posedge clk) begin
        if (rst) begin
            res      <= '0;
            flag_inv <= 1'b0;
            flag_den <= 1'b0;
            ctrl_bad <= 1'b0;
        end else begin
            res      <= nxt_res;
            flag_inv <= nxt_inv;
            flag_den <= nxt_den;
            ctrl_bad <= nxt_bad;
        end
    end

endmodule

// File: rtl/rsel_unit_chk.sv
module rsel_unit_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int CTRL_W = 8,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst,
    input logic [W-1:0]      op_a,
    input logic [W-1:0]      op_b,
    input logic [CTRL_W-1:0] ctrl,
    input logic [W-1:0]      res,
    input logic              flag_inv,
    input logic              flag_den,
    input logic              ctrl_bad
);

    logic any_snan;
    always_comb begin
        any_snan = ((&op_a[W-2:FRAC_W]) && !op_a[FRAC_W-1] && (|op_a[FRAC_W-2:0]))
                || ((&op_b[W-2:FRAC_W]) && !op_b[FRAC_W-1] && (|op_b[FRAC_W-2:0]));
    end

    AST_INV_QUIET: assert property (@(posedge clk) disable iff (rst)
        flag_inv |-> ((&res[W-2:FRAC_W]) && res[FRAC_W-1])); // R4

    AST_SNAN_FLAGS: assert property (@(posedge clk) disable iff (rst)
        any_snan |=> flag_inv); // R4

    AST_INV_NO_DEN: assert property (@(posedge clk) disable iff (rst)
        flag_inv |-> !flag_den); // R8

    AST_SIGN_SET: assert property (@(posedge clk) disable iff (rst)
        (ctrl[3:2] == 2'b11 && !any_snan) |=> res[W-1]); // R3

    AST_SIGN_CLR: assert property (@(posedge clk) disable iff (rst)
        (ctrl[3:2] == 2'b10 && !any_snan) |=> !res[W-1]); // R3

    AST_CTRL_BAD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctrl_bad == $past(|ctrl[CTRL_W-1:4]))); // R9

endmodule

bind rsel_unit rsel_unit_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .CTRL_W(CTRL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .ctrl     (ctrl),
    .res      (res),
    .flag_inv (flag_inv),
    .flag_den (flag_den),
    .ctrl_bad (ctrl_bad)
);

// File: tb/tb_rsel_unit.sv
module tb_rsel_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [7:0]  ctrl = '0;
    logic        daz = 1'b0;
    logic [63:0] res;
    logic        flag_inv;
    logic        flag_den;
    logic        ctrl_bad;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rsel_unit dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .ctrl(ctrl), .daz(daz),
        .res(res), .flag_inv(flag_inv), .flag_den(flag_den), .ctrl_bad(ctrl_bad)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  c;
        logic        z;
        logic [63:0] r;
        logic        inv;
        logic        den;
        logic        bad;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        '{"R2", 64'h3FF0000000000000, 64'h4000000000000000, 8'h04, 1'b0, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R2", 64'h3FF0000000000000, 64'h4000000000000000, 8'h05, 1'b0, 64'h4000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R2", 64'hBFF0000000000000, 64'h4000000000000000, 8'h04, 1'b0, 64'hBFF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R2", 64'hC000000000000000, 64'hBFF0000000000000, 8'h05, 1'b0, 64'hBFF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R2", 64'hC000000000000000, 64'h3FF0000000000000, 8'h06, 1'b0, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R2", 64'hBFF0000000000000, 64'h4000000000000000, 8'h07, 1'b0, 64'h4000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R3", 64'hC09F400000000000, 64'h408FF80000000000, 8'h02, 1'b0, 64'hC08FF80000000000, 1'b0, 1'b0, 1'b0},
        '{"R3", 64'hBFF0000000000000, 64'hC000000000000000, 8'h09, 1'b0, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R3", 64'h3FF0000000000000, 64'h4000000000000000, 8'h0C, 1'b0, 64'hBFF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R3", 64'hC000000000000000, 64'h3FF0000000000000, 8'h01, 1'b0, 64'hBFF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R4", 64'h7FF0000000000001, 64'h3FF0000000000000, 8'h0C, 1'b0, 64'h7FF8000000000001, 1'b1, 1'b0, 1'b0},
        '{"R4", 64'h7FF8000000000000, 64'hFFF0000000000002, 8'h08, 1'b0, 64'hFFF8000000000002, 1'b1, 1'b0, 1'b0},
        '{"R4", 64'hFFF0000000000002, 64'h7FF0000000000001, 8'h00, 1'b0, 64'hFFF8000000000002, 1'b1, 1'b0, 1'b0},
        '{"R5", 64'h3FF0000000000000, 64'h7FF8000000000000, 8'h0D, 1'b0, 64'hBFF0000000000000, 1'b0, 1'b0, 1'b0},
        '{"R5", 64'h7FF8000000000123, 64'h4000000000000000, 8'h04, 1'b0, 64'h4000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R5", 64'h7FF8000000000123, 64'hFFF8000000000000, 8'h0C, 1'b0, 64'hFFF8000000000123, 1'b0, 1'b0, 1'b0},
        '{"R6", 64'h0000000000000000, 64'h8000000000000000, 8'h04, 1'b0, 64'h8000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R6", 64'h8000000000000000, 64'h0000000000000000, 8'h05, 1'b0, 64'h0000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R6", 64'h0000000000000000, 64'h8000000000000000, 8'h06, 1'b0, 64'h8000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R6", 64'h8000000000000000, 64'h0000000000000000, 8'h07, 1'b0, 64'h0000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R7", 64'h4014000000000000, 64'hC014000000000000, 8'h06, 1'b0, 64'hC014000000000000, 1'b0, 1'b0, 1'b0},
        '{"R7", 64'hC014000000000000, 64'h4014000000000000, 8'h07, 1'b0, 64'h4014000000000000, 1'b0, 1'b0, 1'b0},
        '{"R8", 64'h0000000000000001, 64'h3FF0000000000000, 8'h04, 1'b0, 64'h0000000000000001, 1'b0, 1'b1, 1'b0},
        '{"R8", 64'h0000000000000001, 64'h3FF0000000000000, 8'h04, 1'b1, 64'h0000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R8", 64'h0000000000000001, 64'h7FF8000000000000, 8'h04, 1'b0, 64'h0000000000000001, 1'b0, 1'b0, 1'b0},
        '{"R8", 64'h8000000000000001, 64'h0000000000000000, 8'h04, 1'b1, 64'h8000000000000000, 1'b0, 1'b0, 1'b0},
        '{"R8", 64'h8000000000000001, 64'h0000000000000000, 8'h04, 1'b0, 64'h8000000000000001, 1'b0, 1'b1, 1'b0},
        '{"R8", 64'h7FF0000000000001, 64'h0000000000000005, 8'h04, 1'b0, 64'h7FF8000000000001, 1'b1, 1'b0, 1'b0},
        '{"R9", 64'h3FF0000000000000, 64'h4000000000000000, 8'hF4, 1'b0, 64'h3FF0000000000000, 1'b0, 1'b0, 1'b1},
        '{"R9", 64'h3FF0000000000000, 64'h4000000000000000, 8'h75, 1'b0, 64'h4000000000000000, 1'b0, 1'b0, 1'b1},
        '{"R2", 64'h4000000000000000, 64'h4000000000000000, 8'h06, 1'b0, 64'h4000000000000000, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [66:0] act, input logic [66:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got res/inv/den/bad=%h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset clears outputs even with live inputs
        op_a = 64'h3FF0000000000000;
        op_b = 64'h7FF0000000000001;
        ctrl = 8'hF0;
        repeat (3) @(negedge clk);
        check("R1", {res, flag_inv, flag_den, ctrl_bad}, 67'd0);
        rst = 1'b0;

        // Table walk: drive at a falling edge, sample one cycle later
        for (int i = 0; i < NV; i++) begin
            op_a = VEC[i].a;
            op_b = VEC[i].b;
            ctrl = VEC[i].c;
            daz  = VEC[i].z;
            @(negedge clk);
            check(string'(VEC[i].tag), {res, flag_inv, flag_den, ctrl_bad},
                  {VEC[i].r, VEC[i].inv, VEC[i].den, VEC[i].bad});
        end

        // R1: new inputs do not show before the next rising edge
        op_a = 64'hC000000000000000;
        op_b = 64'h3FF0000000000000;
        ctrl = 8'h04;
        daz  = 1'b0;
        #4;
        check("R1", {res, flag_inv, flag_den, ctrl_bad},
              {64'h4000000000000000, 3'b000});
        @(negedge clk);
        check("R1", {res, flag_inv, flag_den, ctrl_bad},
              {64'hC000000000000000, 3'b000});

        // R1: reset mid-run clears the registered result
        rst = 1'b1;
        @(negedge clk);
        check("R1", {res, flag_inv, flag_den, ctrl_bad}, 67'd0);
        rst = 1'b0;

        // R9: upper control bits leave an sNaN result and flags untouched
        op_a = 64'h7FF0000000000001;
        op_b = 64'h3FF0000000000000;
        ctrl = 8'hAC;
        @(negedge clk);
        check("R9", {res, flag_inv, flag_den, ctrl_bad},
              {64'h7FF8000000000001, 3'b101});

        finish_run();
    end

endmodule